// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Array

This block is a programmable logic array. It computes a set of sum-of-products functions from a vector of live inputs. Two bit matrices set the functions. The first, the literal plane, chooses which literals (true or complemented input) each product term uses. The second, the term plane, chooses which product terms each output collects. Both matrices are loaded at run time, so no logic function is fixed in the hardware. Any set of expressions that needs no more product terms than the array has will fit, and the expressions do not have to be minimised first.

Configuration enters one bit per clock on a serial shift chain into a staging register. A single load strobe copies the staged image into the active configuration. The outputs are purely combinational from the inputs and the active configuration. A second, rotating serial chain reads the active image back out in the order it was written. With the default sizes (12 inputs, 50 product terms, 12 outputs) the image holds 1200 literal-plane bits and 600 term-plane bits, 1800 in all.

Top module: `sop_array`

## Requirements
- R1: While `rst` is high at a clock edge, the staging, active and readback images are all cleared. After that edge `out_vec` is 0 for every input, and `rb_bit` is 0.
- R2: The image is 2·N_IN·N_TERM + N_TERM·N_OUT bits long, and the k-th bit shifted in lands at image index k. Literal-plane bit of term t, input i sits at t·2·N_IN + 2·i for the true literal and at t·2·N_IN + 2·i + 1 for the complement. Term-plane bit for term t feeding output o sits at 2·N_IN·N_TERM + t·N_OUT + o.
- R3: A bit is shifted into staging on every edge where `cfg_en` is high. The staged image drives the outputs only from the edge at which `cfg_load` is high. Shifting without a load leaves `out_vec` unchanged. A load on the same edge as a shift captures the image as it stood before that shift.
- R4: A product term is the AND of its connected literals. A term with no connected literal is 1.
- R5: A term connected to both an input and that input's complement is 0 for every input value.
- R6: Each output is the OR of the product terms connected to it. An output with no connected term is 0.
- R7: Any product term may feed any number of outputs at once.
- R8: `out_vec` follows `in_vec` with no clock latency.
- R9: After a load, `rb_bit` shows active image bit 0. Each edge with `rb_shift` high and `cfg_load` low advances `rb_bit` to the next index, and it wraps to index 0 after the last bit. When `cfg_load` and `rb_shift` are high on the same edge, the load wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift one configuration bit into staging |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copy the staged image to the active image and restart readback |
| rb_shift | input | 1 | Advance the readback position by one bit |
| in_vec | input | N_IN | Live input variables |
| out_vec | output | N_OUT | Sum-of-products results |
| rb_bit | output | 1 | Active image bit at the current readback position |

## Verification
`out_vec` is a zero-cycle function of `in_vec`. It changes only one edge after a `cfg_load`, reset or other configuration event. `rb_bit` also moves one edge after `rb_shift` or `cfg_load`. The bench drives every input at the falling edge. For the same-cycle input dependence it samples 1 ns after the drive. For configuration events it samples 1 ns after the following rising edge. In both cases it compares against a behavioural model that updates on that same rising edge. Directed checks at the falling edge cover the pre-load hold, the reset clear and the readback stream bit by bit.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_COMP = 1'b1
    } lit_pol_e;

    // Position of one literal inside the literal plane
    function automatic int and_bit_idx(int n_in, int term, int var_i, lit_pol_e pol);
        return term * 2 * n_in + 2 * var_i + int'(pol);
    endfunction

    // Position of one term->output link, relative to the start of the term plane
    function automatic int or_bit_idx(int n_out, int term, int outp);
        return term * n_out + outp;
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
    parameter int TOTAL = 1800
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic             cfg_load,
    input  logic             rb_shift,
    output logic [TOTAL-1:0] active_cfg,
    output logic             rb_bit
);

    logic [TOTAL-1:0] stage_q;
    logic [TOTAL-1:0] active_q;
    logic [TOTAL-1:0] rb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            active_q <= '0;
            rb_q     <= '0;
        end else begin
            if (cfg_en) begin
                stage_q <= {cfg_bit, stage_q[TOTAL-1:1]};
            end
            if (cfg_load) begin
                active_q <= stage_q;
                rb_q     <= stage_q;
            end else if (rb_shift) begin
                rb_q <= {rb_q[0], rb_q[TOTAL-1:1]};
            end
        end
    end

    assign active_cfg = active_q;
    assign rb_bit     = rb_q[0];

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
    import sop_pkg::*;
#(
    parameter int N_IN   = 12,
    parameter int N_TERM = 50,
    localparam int LITS  = 2 * N_IN
) (
    input  logic [N_IN-1:0]        in_vec,
    input  logic [LITS*N_TERM-1:0] and_cfg,
    output logic [N_TERM-1:0]      term_vec
);

    logic [LITS-1:0] lit_bus;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit_bus[and_bit_idx(N_IN, 0, i, POL_TRUE)] = in_vec[i];
        assign lit_bus[and_bit_idx(N_IN, 0, i, POL_COMP)] = ~in_vec[i];
    end

    // An unconnected literal counts as 1; a term with no literals is 1
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        assign term_vec[t] = &(lit_bus | ~and_cfg[t*LITS +: LITS]);
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_pkg::*;
#(
    parameter int N_TERM = 50,
    parameter int N_OUT  = 12
) (
    input  logic [N_TERM-1:0]       term_vec,
    input  logic [N_TERM*N_OUT-1:0] or_cfg,
    output logic [N_OUT-1:0]        out_vec
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_TERM-1:0] col;
        for (genvar t = 0; t < N_TERM; t++) begin : g_col
            assign col[t] = or_cfg[or_bit_idx(N_OUT, t, o)];
        end
        assign out_vec[o] = |(term_vec & col);
    end

endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int N_IN   = 12,
    parameter int N_TERM = 50,
    parameter int N_OUT  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic             cfg_load,
    input  logic             rb_shift,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec,
    output logic             rb_bit
);

    localparam int AND_BITS = 2 * N_IN * N_TERM;
    localparam int OR_BITS  = N_TERM * N_OUT;
    localparam int TOTAL    = AND_BITS + OR_BITS;

    logic [TOTAL-1:0]  cfg_active;
    logic [N_TERM-1:0] term_vec;

    sop_cfg_chain #(.TOTAL(TOTAL)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_en),
        .cfg_bit   (cfg_bit),
        .cfg_load  (cfg_load),
        .rb_shift  (rb_shift),
        .active_cfg(cfg_active),
        .rb_bit    (rb_bit)
    );

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_vec  (in_vec),
        .and_cfg (cfg_active[AND_BITS-1:0]),
        .term_vec(term_vec)
    );

    sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term_vec(term_vec),
        .or_cfg  (cfg_active[TOTAL-1:AND_BITS]),
        .out_vec (out_vec)
    );

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int N_IN   = 12,
    parameter int N_TERM = 50,
    parameter int N_OUT  = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_load,
    input logic [N_IN-1:0]  in_vec,
    input logic [N_OUT-1:0] out_vec,
    input logic             rb_bit,
    input logic [N_TERM-1:0] term_vec,
    input logic             act_first
);

    // R1: leaving reset, everything reads as cleared
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_vec == '0 && rb_bit == 1'b0));

    // R3: with no load and steady inputs the outputs do not move
    p_hold_without_load_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_load) && !$past(rst) && $stable(in_vec)) |-> $stable(out_vec));

    // R6: no true product term means every sum is 0
    p_no_terms_no_out_r6: assert property (@(posedge clk) disable iff (rst)
        (term_vec == '0) |-> (out_vec == '0));

    // R9: readback restarts at image bit 0 after a load
    p_readback_start_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_load) && !$past(rst)) |-> (rb_bit == act_first));

endmodule

bind sop_array sop_array_chk #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .in_vec   (in_vec),
    .out_vec  (out_vec),
    .rb_bit   (rb_bit),
    .term_vec (term_vec),
    .act_first(cfg_active[0])
);

// File: tb/sop_array_tb.sv
`timescale 1ns/1ps
module sop_array_tb;

    localparam int N_IN   = 12;
    localparam int N_TERM = 50;
    localparam int N_OUT  = 12;
    localparam int LITS   = 2 * N_IN;
    localparam int ANDB   = LITS * N_TERM;
    localparam int TOTAL  = ANDB + N_TERM * N_OUT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0, cfg_bit = 1'b0, cfg_load = 1'b0, rb_shift = 1'b0;
    logic [N_IN-1:0]  in_vec = '0;
    logic [N_OUT-1:0] out_vec;
    logic             rb_bit;

    int checks = 0;
    int errors = 0;

    bit want    [TOTAL];
    bit ref_stg [TOTAL];
    bit ref_act [TOTAL];
    int rb_ptr = 0;

    always #2.5 clk = ~clk;

    sop_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .cfg_load(cfg_load), .rb_shift(rb_shift), .in_vec(in_vec),
        .out_vec(out_vec), .rb_bit(rb_bit)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N_OUT-1:0] model_out(logic [N_IN-1:0] iv);
        logic [N_OUT-1:0] r = '0;
        for (int t = 0; t < N_TERM; t++) begin
            bit prod = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                if (ref_act[t*LITS + 2*i]     && !iv[i]) prod = 1'b0;
                if (ref_act[t*LITS + 2*i + 1] &&  iv[i]) prod = 1'b0;
            end
            for (int o = 0; o < N_OUT; o++)
                if (prod && ref_act[ANDB + t*N_OUT + o]) r[o] = 1'b1;
        end
        return r;
    endfunction

    // Reference model, updated on the same edge as the design
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TOTAL; k++) begin
                ref_stg[k] <= 1'b0;
                ref_act[k] <= 1'b0;
            end
            rb_ptr <= 0;
        end else begin
            if (cfg_en) begin
                for (int k = 0; k < TOTAL - 1; k++) ref_stg[k] <= ref_stg[k+1];
                ref_stg[TOTAL-1] <= cfg_bit;
            end
            if (cfg_load) begin
                for (int k = 0; k < TOTAL; k++) ref_act[k] <= ref_stg[k];
                rb_ptr <= 0;
            end else if (rb_shift) begin
                rb_ptr <= (rb_ptr + 1) % TOTAL;
            end
        end
    end

    // Per-cycle comparison, 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            check("R8 out_vec vs model", 32'(out_vec), 32'(model_out(in_vec)));
            check("R9 rb_bit vs model", 32'(rb_bit), 32'(ref_act[rb_ptr]));
        end
    end

    task automatic clear_want();
        for (int k = 0; k < TOTAL; k++) want[k] = 1'b0;
    endtask

    task automatic set_lit(int t, int i, bit comp);
        want[t*LITS + 2*i + int'(comp)] = 1'b1;
    endtask

    task automatic set_link(int t, int o);
        want[ANDB + t*N_OUT + o] = 1'b1;
    endtask

    task automatic shift_want();
        for (int k = 0; k < TOTAL; k++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_bit = want[k];
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic pulse_load();
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic set_in(logic [N_IN-1:0] v);
        in_vec = v;
        #1;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        set_in('1);
        check("R1 out after reset", 32'(out_vec), 32'h0);
        check("R1 rb_bit after reset", 32'(rb_bit), 32'h0);

        // Configuration A
        clear_want();
        set_lit(0, 0, 1'b0); set_lit(0, 1, 1'b1); set_link(0, 0);  // in0 & ~in1 -> out0
        set_lit(4, 4, 1'b0); set_lit(4, 5, 1'b0); set_link(4, 0);  // in4 & in5   -> out0
        set_link(1, 1);                                          // empty term  -> out1
        set_lit(2, 2, 1'b0); set_lit(2, 2, 1'b1); set_link(2, 2);  // in2 & ~in2  -> out2
        set_lit(3, 3, 1'b0); set_link(3, 4); set_link(3, 5);     // in3 -> out4, out5
        set_lit(49, 11, 1'b1); set_link(49, 11);                 // last term: ~in11 -> out11
        shift_want();
        set_in(12'h000);
        check("R3 no effect before load", 32'(out_vec), 32'h0);
        pulse_load();

        set_in(12'h000);
        check("R4 empty term is 1", 32'(out_vec[1]), 32'h1);
        check("R6 unconnected output is 0", 32'(out_vec[3]), 32'h0);
        check("R2 last term reaches out11", 32'(out_vec[11]), 32'h1);
        check("R6 sum of products out0 low", 32'(out_vec[0]), 32'h0);
        set_in(12'h001);
        check("R4 in0&~in1 term", 32'(out_vec[0]), 32'h1);
        set_in(12'h003);
        check("R4 complement literal blocks", 32'(out_vec[0]), 32'h0);
        set_in(12'h030);
        check("R6 second term feeds out0", 32'(out_vec[0]), 32'h1);
        set_in(12'h000); set_in(12'h004);
        check("R5 x&~x is 0 (x=1)", 32'(out_vec[2]), 32'h0);
        set_in(12'h000);
        check("R5 x&~x is 0 (x=0)", 32'(out_vec[2]), 32'h0);
        set_in(12'h008);
        check("R7 shared term out4", 32'(out_vec[4]), 32'h1);
        check("R7 shared term out5", 32'(out_vec[5]), 32'h1);
        set_in(12'h800);
        check("R8 same-cycle response", 32'(out_vec), 32'h002);

        // Readback of the whole image, then wrap
        @(negedge clk);
        for (int k = 0; k < TOTAL; k++) begin
            check("R9 R2 readback order", 32'(rb_bit), 32'(want[k]));
            rb_shift = 1'b1;
            @(negedge clk);
        end
        rb_shift = 1'b0;
        check("R9 readback wraps", 32'(rb_bit), 32'(want[0]));
        rb_shift = 1'b1;
        repeat (3) @(negedge clk);
        rb_shift = 1'b0;
        check("R9 readback advanced", 32'(rb_bit), 32'(want[3]));
        rb_shift = 1'b1; cfg_load = 1'b1;
        @(negedge clk);
        rb_shift = 1'b0; cfg_load = 1'b0;
        check("R9 load beats shift", 32'(rb_bit), 32'(want[0]));

        // Mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        set_in(12'h000);
        check("R1 out after mid reset", 32'(out_vec), 32'h0);
        check("R1 rb after mid reset", 32'(rb_bit), 32'h0);

        // Configuration B: sparse pseudo-random image
        for (int k = 0; k < TOTAL; k++)
            want[k] = (k < ANDB) ? (($urandom % 10) == 0) : (($urandom % 4) == 0);
        shift_want();
        // load coincides with one more shift: load must take the pre-shift image
        cfg_en = 1'b1; cfg_bit = 1'b1; cfg_load = 1'b1;
        @(negedge clk);
        cfg_en = 1'b0; cfg_load = 1'b0;
        set_in(12'h000);
        check("R3 load with shift uses old image", 32'(rb_bit), 32'(want[0]));
        for (int n = 0; n < 400; n++) begin
            in_vec = N_IN'($urandom);
            rb_shift = n[0];
            @(negedge clk);
        end
        rb_shift = 1'b0;
        pulse_load();
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule